// File: doc/BRIEF.md
# Multi-tap filtering flash converter encoder

This block sits behind the comparator bank of a flash converter. Every cycle that the strobe `cmp_valid` is high, it takes one comparator vector with one bit per quantisation level. It pushes that vector into a short history of delay taps. It then reduces all taps of all comparators to one binary number through a pipelined adder tree. The tree adds bits; it does not search for the top of the thermometer. So a bit out of place (a bubble) costs one count and no more, and summing over several taps forms an FIR filter in front of the encoding. That filter puts deep notches at multiples of the tap rate, so the analog anti-alias filter ahead of the comparators can be of much lower order.

Two weightings can be chosen at elaboration time. The boxcar weighting gives every tap a weight of one, which is a sin(x)/x response. The binomial weighting gives each tap a weight from a row of Pascal's triangle, which widens the notches. The binomial weights are built by a cascade of pairwise additions, so neither mode uses a multiplier. The output word is wider than the comparator count alone would need, because summing the taps adds resolution.

Top module: `flash_boxcar_encoder`

## Requirements
- R1: While `rst_n` is low, and in the cycle after a clock edge that sees it low, `out_valid` is 0 and `out_word` is 0.
- R2: After reset, the first N_TAPS-1 accepted vectors produce no `out_valid`. The N_TAPS-th accepted vector produces the first output.
- R3: In boxcar mode, `out_word` equals the total number of ones in the N_TAPS most recently accepted vectors. This holds for any bit pattern, including non-thermometer (bubbled) vectors.
- R4: In binomial mode, `out_word` equals the sum over j = 0..N_TAPS-1 of C(N_TAPS-1, j) times the number of ones in the j-th most recent accepted vector (j = 0 is the newest).
- R5: `out_valid` rises exactly LAT cycles after the clock edge that accepts the vector completing the window. LAT is 2 + ceil(log2(N_TAPS)) in boxcar mode and N_TAPS + 1 in binomial mode. Each such vector produces exactly one output cycle, in order.
- R6: A vector presented while `cmp_valid` is low is ignored. It neither enters the taps nor produces an output.
- R7: `out_word` is ceil(log2(N_CMP*G+1)) bits wide, where G is N_TAPS for boxcar and 2^(N_TAPS-1) for binomial. A full window of all-ones vectors gives exactly N_CMP*G, with no wrap.
- R8: A reset in mid-stream discards the tap history. N_TAPS fresh accepted vectors are needed before the next output, and that output depends only on those vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_valid | input | 1 | Strobe: the vector on `cmp_therm` is accepted this cycle |
| cmp_therm | input | N_CMP | Comparator outputs, one bit per level |
| out_valid | output | 1 | `out_word` holds a new filtered sample |
| out_word | output | OUT_W | Weighted sum of ones over the tap window |

## Verification
A tap that shifts at the wrong time, or keeps stale data, makes the count wrong on the first output whose window covers that tap. So a broken shift or a broken refill after reset shows at the ports within N_TAPS samples. An adder level that drops a carry or pairs the wrong nodes only shows when the bits reaching it are non-zero. For that reason every 7-bit vector, bubbled or not, is driven through a small configuration in both weightings, and each output is compared with an arithmetic sum. A valid bit that slips in the pipeline shows on the very next output, as a latency one cycle off or as an output with no sample behind it.

// File: rtl/fenc_pkg.sv
// Package: shared types and derived sizes for the flash encoder.
// Assumes N_TAPS >= 2 so that every tree has at least one level.
package fenc_pkg;

    typedef enum logic {
        WEIGHT_BOXCAR   = 1'b0,
        WEIGHT_BINOMIAL = 1'b1
    } weight_mode_e;

    // Sum of all tap weights for the chosen mode.
    function automatic int tap_gain(input int taps, input weight_mode_e mode);
        return (mode == WEIGHT_BINOMIAL) ? (1 << (taps - 1)) : taps;
    endfunction

    // Bits needed for the largest possible output value.
    function automatic int word_width(input int n_cmp, input int taps, input weight_mode_e mode);
        return $clog2(n_cmp * tap_gain(taps, mode) + 1);
    endfunction

    // Registered adder levels in the reduction tree.
    function automatic int tree_depth(input int taps, input weight_mode_e mode);
        return (mode == WEIGHT_BINOMIAL) ? (taps - 1) : $clog2(taps);
    endfunction

    // Cycles from the accepting edge to out_valid: tap stage, count stage, tree.
    function automatic int pipe_latency(input int taps, input weight_mode_e mode);
        return 2 + tree_depth(taps, mode);
    endfunction

endpackage

// File: rtl/fenc_tap_line.sv
// Module: delay-tap history of comparator vectors.
// Tap 0 holds the newest accepted vector. The taps move only when cmp_valid
// is high. A fill counter marks when every tap holds a real sample.
module fenc_tap_line #(
    parameter int N_CMP  = 15,
    parameter int N_TAPS = 10
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          cmp_valid,
    input  logic [N_CMP-1:0]              cmp_therm,
    output logic [N_TAPS-1:0][N_CMP-1:0]  taps,
    output logic                          frame_valid
);
    localparam int FILL_W = $clog2(N_TAPS + 1);

    logic [FILL_W-1:0] fill_q;

    // Shift the history on each accepted vector and flag complete windows.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taps        <= '0;
            fill_q      <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= cmp_valid && (fill_q >= FILL_W'(N_TAPS - 1));
            if (cmp_valid) begin
                taps <= {taps[N_TAPS-2:0], cmp_therm};
                if (fill_q != FILL_W'(N_TAPS)) begin
                    fill_q <= fill_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fenc_tap_count.sv
// Module: per-tap population count, registered.
// Each tap's bits are added one by one, so bubbles count like any other
// set bit. The results are widened to the output width for the tree.
module fenc_tap_count #(
    parameter int N_CMP  = 15,
    parameter int N_TAPS = 10,
    parameter int OW     = 8
)(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [N_TAPS-1:0][N_CMP-1:0]  taps,
    input  logic                          frame_valid,
    output logic [N_TAPS-1:0][OW-1:0]     counts,
    output logic                          counts_valid
);
    logic [N_TAPS-1:0][OW-1:0] count_d;

    // Count the ones of every tap.
    always_comb begin
        for (int t = 0; t < N_TAPS; t++) begin
            count_d[t] = '0;
            for (int b = 0; b < N_CMP; b++) begin
                count_d[t] = count_d[t] + OW'(taps[t][b]);
            end
        end
    end

    // Register the counts together with their valid tag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            counts       <= '0;
            counts_valid <= 1'b0;
        end else begin
            counts       <= count_d;
            counts_valid <= frame_valid;
        end
    end

endmodule

// File: rtl/fenc_boxcar_tree.sv
// Module: uniform-weight reduction tree.
// A pipelined binary adder tree with one register per level. The leaves are
// padded with zeros up to a power of two. Every tap weighs one.
module fenc_boxcar_tree #(
    parameter int N_TAPS = 10,
    parameter int OW     = 8
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_TAPS-1:0][OW-1:0]  leaf,
    input  logic                       leaf_valid,
    output logic [OW-1:0]              sum,
    output logic                       sum_valid
);
    localparam int DEPTH  = $clog2(N_TAPS);
    localparam int PADDED = 1 << DEPTH;

    logic [DEPTH-1:0] vld_q;

    for (genvar lv = 0; lv <= DEPTH; lv++) begin : lvl_g
        localparam int CNT = PADDED >> lv;
        logic [OW-1:0] node [CNT];
        if (lv == 0) begin : leaf_g
            // Load the tap counts and pad the unused leaves with zero.
            always_comb begin
                for (int i = 0; i < CNT; i++) begin
                    node[i] = '0;
                end
                for (int i = 0; i < N_TAPS; i++) begin
                    node[i] = leaf[i];
                end
            end
        end else begin : add_g
            // Add adjacent pairs of the level below.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < CNT; i++) node[i] <= '0;
                end else begin
                    for (int i = 0; i < CNT; i++) begin
                        node[i] <= lvl_g[lv-1].node[2*i] + lvl_g[lv-1].node[2*i+1];
                    end
                end
            end
        end
    end

    // Carry the valid tag alongside the adder levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= leaf_valid;
            for (int k = 1; k < DEPTH; k++) vld_q[k] <= vld_q[k-1];
        end
    end

    assign sum       = lvl_g[DEPTH].node[0];
    assign sum_valid = vld_q[DEPTH-1];

endmodule

// File: rtl/fenc_pascal_tree.sv
// Module: binomial-weight reduction tree.
// N_TAPS-1 registered levels, each adding neighbouring pairs. The single
// final node weighs tap j by C(N_TAPS-1, j), so no multiplier is needed.
module fenc_pascal_tree #(
    parameter int N_TAPS = 10,
    parameter int OW     = 8
)(
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_TAPS-1:0][OW-1:0]  leaf,
    input  logic                       leaf_valid,
    output logic [OW-1:0]              sum,
    output logic                       sum_valid
);
    localparam int DEPTH = N_TAPS - 1;

    logic [DEPTH-1:0] vld_q;

    for (genvar lv = 0; lv <= DEPTH; lv++) begin : lvl_g
        localparam int CNT = N_TAPS - lv;
        logic [OW-1:0] node [CNT];
        if (lv == 0) begin : leaf_g
            // Level zero is the row of tap counts.
            always_comb begin
                for (int i = 0; i < CNT; i++) node[i] = leaf[i];
            end
        end else begin : add_g
            // Overlapping pair sums build the next Pascal row.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    for (int i = 0; i < CNT; i++) node[i] <= '0;
                end else begin
                    for (int i = 0; i < CNT; i++) begin
                        node[i] <= lvl_g[lv-1].node[i] + lvl_g[lv-1].node[i+1];
                    end
                end
            end
        end
    end

    // Carry the valid tag alongside the adder levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else begin
            vld_q[0] <= leaf_valid;
            for (int k = 1; k < DEPTH; k++) vld_q[k] <= vld_q[k-1];
        end
    end

    assign sum       = lvl_g[DEPTH].node[0];
    assign sum_valid = vld_q[DEPTH-1];

endmodule

// File: rtl/flash_boxcar_encoder.sv
// Module: filtering flash encoder top.
// Tap history, then per-tap counts, then a reduction tree chosen by
// WEIGHT_MODE. Assumes N_TAPS >= 2 and N_CMP >= 1. Latency is fixed per mode.
module flash_boxcar_encoder
    import fenc_pkg::*;
#(
    parameter int           N_CMP       = 15,
    parameter int           N_TAPS      = 10,
    parameter weight_mode_e WEIGHT_MODE = WEIGHT_BOXCAR,
    localparam int          OUT_W       = word_width(N_CMP, N_TAPS, WEIGHT_MODE)
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmp_valid,
    input  logic [N_CMP-1:0]  cmp_therm,
    output logic              out_valid,
    output logic [OUT_W-1:0]  out_word
);
    logic [N_TAPS-1:0][N_CMP-1:0] taps;
    logic                         frame_valid;
    logic [N_TAPS-1:0][OUT_W-1:0] counts;
    logic                         counts_valid;

    fenc_tap_line #(.N_CMP(N_CMP), .N_TAPS(N_TAPS)) u_taps (
        .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid), .cmp_therm(cmp_therm),
        .taps(taps), .frame_valid(frame_valid)
    );

    fenc_tap_count #(.N_CMP(N_CMP), .N_TAPS(N_TAPS), .OW(OUT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .taps(taps), .frame_valid(frame_valid),
        .counts(counts), .counts_valid(counts_valid)
    );

    if (WEIGHT_MODE == WEIGHT_BINOMIAL) begin : pascal_g
        fenc_pascal_tree #(.N_TAPS(N_TAPS), .OW(OUT_W)) u_tree (
            .clk(clk), .rst_n(rst_n), .leaf(counts), .leaf_valid(counts_valid),
            .sum(out_word), .sum_valid(out_valid)
        );
    end else begin : boxcar_g
        fenc_boxcar_tree #(.N_TAPS(N_TAPS), .OW(OUT_W)) u_tree (
            .clk(clk), .rst_n(rst_n), .leaf(counts), .leaf_valid(counts_valid),
            .sum(out_word), .sum_valid(out_valid)
        );
    end

endmodule

// File: rtl/fenc_checker.sv
// Module: property checker for the flash encoder, bound to the top.
// Keeps its own count of accepted vectors and a delay line of
// window-complete strobes, and compares them with the outputs.
module fenc_checker
    import fenc_pkg::*;
#(
    parameter int           N_CMP       = 15,
    parameter int           N_TAPS      = 10,
    parameter weight_mode_e WEIGHT_MODE = WEIGHT_BOXCAR,
    localparam int          OUT_W       = word_width(N_CMP, N_TAPS, WEIGHT_MODE)
)(
    input logic              clk,
    input logic              rst_n,
    input logic              cmp_valid,
    input logic              out_valid,
    input logic [OUT_W-1:0]  out_word
);
    localparam int LAT    = pipe_latency(N_TAPS, WEIGHT_MODE);
    localparam int SEEN_W = $clog2(N_TAPS + 1);
    localparam int MAXV   = N_CMP * tap_gain(N_TAPS, WEIGHT_MODE);

    logic [SEEN_W-1:0] seen_q;
    logic [LAT-1:0]    due_q;

    // Count accepted vectors since reset, saturating at a full window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else if (cmp_valid && seen_q != SEEN_W'(N_TAPS)) begin
            seen_q <= seen_q + 1'b1;
        end
    end

    // Delay the window-complete strobes by the expected latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            due_q <= '0;
        end else begin
            due_q[0] <= cmp_valid && (seen_q >= SEEN_W'(N_TAPS - 1));
            for (int k = 1; k < LAT; k++) due_q[k] <= due_q[k-1];
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_word == '0));

    assert_fill_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (seen_q == SEEN_W'(N_TAPS)));

    assert_output_on_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
        due_q[LAT-1] |-> out_valid);

    assert_no_orphan_output_R5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> due_q[LAT-1]);

    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_word <= OUT_W'(MAXV)));

endmodule

bind flash_boxcar_encoder fenc_checker #(
    .N_CMP(N_CMP), .N_TAPS(N_TAPS), .WEIGHT_MODE(WEIGHT_MODE)
) u_fenc_chk (
    .clk(clk), .rst_n(rst_n), .cmp_valid(cmp_valid),
    .out_valid(out_valid), .out_word(out_word)
);

// File: tb/flash_boxcar_encoder_tb.sv
// Bench: two small instances (boxcar and binomial) get the same stimulus.
// Expected words come from arithmetic on the accepted vectors.
module flash_boxcar_encoder_tb;

    localparam int CLK_PERIOD = 10;
    localparam int N   = 7;
    localparam int T   = 5;
    localparam int GU  = T;
    localparam int GP  = 1 << (T - 1);
    localparam int OWU = $clog2(N * GU + 1);
    localparam int OWP = $clog2(N * GP + 1);
    localparam int LAT_U = 2 + $clog2(T);
    localparam int LAT_P = T + 1;
    localparam int WATCHDOG = 20000;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           vld;
    logic [N-1:0]   cmp;
    logic           u_valid, p_valid;
    logic [OWU-1:0] u_word;
    logic [OWP-1:0] p_word;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;
    logic [N-1:0] hist [T];
    int nsamp = 0;
    int exp_u[$], t_u[$], exp_p[$], t_p[$];
    int seen_u = 0, seen_p = 0, last_u = -1, last_p = -1;

    flash_boxcar_encoder #(.N_CMP(N), .N_TAPS(T), .WEIGHT_MODE(fenc_pkg::WEIGHT_BOXCAR)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmp_valid(vld), .cmp_therm(cmp),
        .out_valid(u_valid), .out_word(u_word)
    );

    flash_boxcar_encoder #(.N_CMP(N), .N_TAPS(T), .WEIGHT_MODE(fenc_pkg::WEIGHT_BINOMIAL)) u_dut_pascal (
        .clk(clk), .rst_n(rst_n), .cmp_valid(vld), .cmp_therm(cmp),
        .out_valid(p_valid), .out_word(p_word)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Cycle count and watchdog.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > WATCHDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL R5 watchdog: actual=%0d cycles expected<=%0d", cyc, WATCHDOG);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    function automatic int ones(input logic [N-1:0] v);
        int c = 0;
        for (int b = 0; b < N; b++) c += int'(v[b]);
        return c;
    endfunction

    function automatic int binom(input int n, input int k);
        int r = 1;
        for (int i = 0; i < k; i++) r = r * (n - i) / (i + 1);
        return r;
    endfunction

    function automatic logic [N-1:0] therm(input int k);
        logic [N-1:0] v = '0;
        for (int b = 0; b < N; b++) if (b < k) v[b] = 1'b1;
        return v;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Drive one cycle; model the tap window on accepted vectors.
    task automatic drive(input logic [N-1:0] v, input bit valid);
        int eu, ep;
        @(negedge clk);
        vld = valid;
        cmp = v;
        if (valid) begin
            for (int j = T - 1; j > 0; j--) hist[j] = hist[j-1];
            hist[0] = v;
            nsamp++;
            if (nsamp >= T) begin
                eu = 0;
                ep = 0;
                for (int j = 0; j < T; j++) begin
                    eu += ones(hist[j]);
                    ep += binom(T - 1, j) * ones(hist[j]);
                end
                exp_u.push_back(eu); t_u.push_back(cyc);
                exp_p.push_back(ep); t_p.push_back(cyc);
            end
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(7'h55, 1'b0);
    endtask

    // Output monitor for both instances, away from the active edge.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (u_valid) begin
                seen_u++;
                last_u = int'(u_word);
                if (exp_u.size() == 0) begin
                    check(1'b0, "R2 boxcar output without full window", 1, 0);
                end else begin
                    int e, t0;
                    e = exp_u.pop_front(); t0 = t_u.pop_front();
                    check(int'(u_word) == e, "R3 boxcar sum", int'(u_word), e);
                    check(cyc - t0 == LAT_U, "R5 boxcar latency", cyc - t0, LAT_U);
                end
            end
            if (p_valid) begin
                seen_p++;
                last_p = int'(p_word);
                if (exp_p.size() == 0) begin
                    check(1'b0, "R2 binomial output without full window", 1, 0);
                end else begin
                    int e, t0;
                    e = exp_p.pop_front(); t0 = t_p.pop_front();
                    check(int'(p_word) == e, "R4 binomial sum", int'(p_word), e);
                    check(cyc - t0 == LAT_P, "R5 binomial latency", cyc - t0, LAT_P);
                end
            end
        end
    end

    initial begin
        int su, sp;
        rst_n = 1'b0; vld = 1'b0; cmp = '0;
        for (int j = 0; j < T; j++) hist[j] = '0;
        repeat (3) @(negedge clk);
        // R1: quiet outputs under reset
        check(u_valid == 1'b0 && u_word == '0, "R1 boxcar reset state", int'(u_word), 0);
        check(p_valid == 1'b0 && p_word == '0, "R1 binomial reset state", int'(p_word), 0);
        rst_n = 1'b1;

        // R2: T-1 accepted vectors give no output
        for (int i = 0; i < T - 1; i++) drive(therm(N), 1'b1);
        idle(LAT_P + 2);
        check(seen_u == 0, "R2 boxcar silent during fill", seen_u, 0);
        check(seen_p == 0, "R2 binomial silent during fill", seen_p, 0);
        drive(therm(N), 1'b1);
        idle(LAT_P + 2);
        check(seen_u == 1, "R2 boxcar first output on window fill", seen_u, 1);
        check(last_u == N * GU, "R7 boxcar full-scale value", last_u, N * GU);
        check(last_p == N * GP, "R7 binomial full-scale value", last_p, N * GP);

        // R3/R4: thermometer sweep, each level held for two samples
        for (int k = 0; k <= N; k++) begin
            drive(therm(k), 1'b1);
            drive(therm(k), 1'b1);
        end

        // R3/R4: every 7-bit vector, bubbles included
        for (int v = 0; v < (1 << N); v++) drive(N'(v), 1'b1);
        idle(LAT_P + 2);

        // R6: vectors with the strobe low are ignored
        su = seen_u; sp = seen_p;
        for (int i = 0; i < 8; i++) drive(therm(N), 1'b0);
        check(seen_u == su, "R6 boxcar no output from unstrobed vectors", seen_u, su);
        check(seen_p == sp, "R6 binomial no output from unstrobed vectors", seen_p, sp);
        for (int i = 0; i < 45; i++) drive(N'(i * 37 + 11), (i % 3) != 0);
        idle(LAT_P + 2);

        // R8: mid-stream reset discards history
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        nsamp = 0;
        for (int j = 0; j < T; j++) hist[j] = '0;
        su = seen_u; sp = seen_p;
        for (int i = 0; i < T - 1; i++) drive(therm(i + 2), 1'b1);
        idle(LAT_P + 2);
        check(seen_u == su, "R8 boxcar refill after reset", seen_u, su);
        check(seen_p == sp, "R8 binomial refill after reset", seen_p, sp);
        drive(therm(1), 1'b1);
        idle(LAT_P + 2);
        check(seen_u == su + 1, "R8 boxcar output after refill", seen_u, su + 1);
        check(seen_p == sp + 1, "R8 binomial output after refill", seen_p, sp + 1);

        // R5: every accepted full window produced exactly one output
        check(exp_u.size() == 0, "R5 boxcar pending outputs", exp_u.size(), 0);
        check(exp_p.size() == 0, "R5 binomial pending outputs", exp_p.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule